// File: doc/BRIEF.md
# Low-Power Mode Sequencer with Sub-Clock Sleep

This block decides which low-power state a small microcontroller enters when its CPU executes a sleep instruction. It also drives the clock enables that go with each state. Three control bits qualify the request: a standby select, a low-speed enable and a watchdog prescaler select. The block returns to the running state when a qualified interrupt arrives, and it tells the CPU to start exception processing with a single-cycle pulse.

In the sub-clock sleep state, the CPU clock and every peripheral clock enable are turned off, and only the watchdog timer enables stay on. Interrupt lines wake the block only if they pass a per-line enable. Peripheral interrupts must also pass the CPU mask. The non-maskable interrupt wakes the block in every case. A low level on the standby pin overrides everything and forces a separate hardware-standby state. That state is left only through reset with the standby pin high. Everything runs on a single clock, which is the sub-clock, so wake conditions are sampled at its rate.

Top module: `pwr_mode_seq`

## Requirements
- R1: With `stby_n` high, a clock edge that samples `rst_n` low puts `mode` at 0 (running), sets `cpu_clk_en`, all `per_clk_en` and all `wdt_clk_en` high, and makes `exc_start` low in the next cycle.
- R2: In the running state, a `sleep_req` with `ctl_ssel`=0, `ctl_lspd`=1 and `ctl_wdps`=1 moves `mode` to 2 (sub-clock sleep) at the next edge.
- R3: In the running state, a `sleep_req` with `ctl_ssel`=1 moves `mode` to 3 (software standby). A `sleep_req` with `ctl_ssel`=0 and either `ctl_lspd`=0 or `ctl_wdps`=0 moves `mode` to 1 (sleep).
- R4: The clock enables follow `mode`. In mode 0 everything is on. In mode 1 the CPU is off and the peripherals and watchdogs are on. In mode 2 only the watchdogs are on. In modes 3 and 4 everything is off.
- R5: In modes 1, 2 and 3, any of the following returns `mode` to 0 at the next edge: `nmi`, an external line with its enable bit set, or a peripheral line with its enable bit set while `cpu_mask` is 0.
- R6: An external line whose enable bit is 0 does not change `mode`. A peripheral line whose enable bit is 0, or any peripheral line while `cpu_mask` is 1, also does not change `mode`.
- R7: `nmi` wakes the block even while `cpu_mask` is 1.
- R8: `exc_start` is high for exactly one cycle, namely the second cycle of the running state entered by a wake. It stays low when the running state is entered by reset.
- R9: `stby_n` low at a clock edge puts `mode` at 4 (hardware standby) from any state, even while `rst_n` is low. `exc_start` is cleared at the same time.
- R10: Mode 4 is left only by an edge that samples `rst_n` low with `stby_n` high. Interrupts and sleep requests leave it in place.
- R11: `sleep_req` has no effect in any state other than the running state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sub-clock |
| rst_n | input | 1 | Reset pin, active low, sampled synchronously |
| stby_n | input | 1 | Hardware standby pin, active low |
| sleep_req | input | 1 | CPU executed a sleep instruction |
| ctl_ssel | input | 1 | Standby select bit |
| ctl_lspd | input | 1 | Low-speed enable bit |
| ctl_wdps | input | 1 | Watchdog prescaler select bit |
| nmi | input | 1 | Non-maskable interrupt |
| ext_irq | input | N_EXT | External interrupt lines |
| ext_irq_en | input | N_EXT | Per-line external interrupt enables |
| per_irq | input | N_PER | Peripheral interrupt requests |
| per_irq_en | input | N_PER | Per-source peripheral interrupt enables |
| cpu_mask | input | 1 | CPU interrupt mask, blocks peripheral interrupts |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | N_PER | Peripheral clock enables |
| wdt_clk_en | output | N_WDT | Watchdog timer clock enables |
| exc_start | output | 1 | Exception-start pulse after a wake |
| mode | output | 3 | Current state: 0 run, 1 sleep, 2 sub-clock sleep, 3 software standby, 4 hardware standby |

## Verification
The bench builds the block with six external lines and four peripheral sources. At that size the bench can drive each external line on its own as a wake source, and it can exercise a wrong-line or disabled-line case next to every enabled one. A behavioural model runs alongside the design and is compared with it every cycle. The bench walks through all three sleep qualifier combinations, each filtered wake path, the non-maskable override of the mask, and the standby-pin override both while running and while reset is held.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;
   typedef enum logic [2:0] {
      PM_RUN    = 3'd0,
      PM_SLEEP  = 3'd1,
      PM_SUBSLP = 3'd2,
      PM_SWSTBY = 3'd3,
      PM_HWSTBY = 3'd4
   } pm_mode_e;
endpackage

// File: rtl/pwr_wake_qual.sv
module pwr_wake_qual #(
   parameter int N_EXT = 6,
   parameter int N_PER = 8
) (
   input  logic             nmi,
   input  logic [N_EXT-1:0] ext_irq,
   input  logic [N_EXT-1:0] ext_irq_en,
   input  logic [N_PER-1:0] per_irq,
   input  logic [N_PER-1:0] per_irq_en,
   input  logic             cpu_mask,
   output logic             wake
);
   logic [N_EXT-1:0] ext_hit;
   logic [N_PER-1:0] per_hit;

   for (genvar i = 0; i < N_EXT; i++) begin : g_ext
      assign ext_hit[i] = ext_irq[i] & ext_irq_en[i];
   end
   for (genvar j = 0; j < N_PER; j++) begin : g_per
      assign per_hit[j] = per_irq[j] & per_irq_en[j];
   end

   assign wake = nmi | (|ext_hit) | (~cpu_mask & (|per_hit));
endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
   import pwr_mode_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     stby_n,
   input  logic     sleep_req,
   input  logic     ctl_ssel,
   input  logic     ctl_lspd,
   input  logic     ctl_wdps,
   input  logic     wake,
   output pm_mode_e st,
   output logic     exc_start
);
   pm_mode_e nxt;
   logic     take;
   logic     pend;

   always_comb begin
      nxt  = st;
      take = 1'b0;
      if (!stby_n) begin
         nxt = PM_HWSTBY;
      end else if (!rst_n) begin
         nxt = PM_RUN;
      end else begin
         unique case (st)
            PM_RUN: begin
               if (sleep_req) begin
                  if (ctl_ssel)                 nxt = PM_SWSTBY;
                  else if (ctl_lspd && ctl_wdps) nxt = PM_SUBSLP;
                  else                          nxt = PM_SLEEP;
               end
            end
            PM_SLEEP, PM_SUBSLP, PM_SWSTBY: begin
               if (wake) begin
                  nxt  = PM_RUN;
                  take = 1'b1;
               end
            end
            PM_HWSTBY: nxt = PM_HWSTBY;
            default:   nxt = PM_RUN;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      st <= nxt;
      if (!stby_n || !rst_n) begin
         pend      <= 1'b0;
         exc_start <= 1'b0;
      end else begin
         pend      <= take;
         exc_start <= pend;
      end
   end

   // R2
   subslp_entry_chk: assert property (@(posedge clk) disable iff (!rst_n || !stby_n)
      (st == PM_RUN && sleep_req && !ctl_ssel && ctl_lspd && ctl_wdps) |=> st == PM_SUBSLP);

   // R6
   no_wake_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !stby_n)
      ((st == PM_SLEEP || st == PM_SUBSLP || st == PM_SWSTBY) && !wake) |=> st == $past(st));

   // R10
   hwstby_stay_chk: assert property (@(posedge clk) disable iff (!stby_n)
      (st == PM_HWSTBY && rst_n) |=> st == PM_HWSTBY);
endmodule

// File: rtl/pwr_clk_gate_dec.sv
module pwr_clk_gate_dec
   import pwr_mode_pkg::*;
#(
   parameter int N_PER = 8,
   parameter int N_WDT = 2
) (
   input  pm_mode_e         st,
   output logic             cpu_clk_en,
   output logic [N_PER-1:0] per_clk_en,
   output logic [N_WDT-1:0] wdt_clk_en
);
   logic per_on;
   logic wdt_on;

   assign cpu_clk_en = (st == PM_RUN);
   assign per_on     = (st == PM_RUN) || (st == PM_SLEEP);
   assign wdt_on     = per_on || (st == PM_SUBSLP);

   for (genvar j = 0; j < N_PER; j++) begin : g_per
      assign per_clk_en[j] = per_on;
   end
   for (genvar k = 0; k < N_WDT; k++) begin : g_wdt
      assign wdt_clk_en[k] = wdt_on;
   end
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
   import pwr_mode_pkg::*;
#(
   parameter int N_EXT = 6,
   parameter int N_PER = 8,
   parameter int N_WDT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stby_n,
   input  logic             sleep_req,
   input  logic             ctl_ssel,
   input  logic             ctl_lspd,
   input  logic             ctl_wdps,
   input  logic             nmi,
   input  logic [N_EXT-1:0] ext_irq,
   input  logic [N_EXT-1:0] ext_irq_en,
   input  logic [N_PER-1:0] per_irq,
   input  logic [N_PER-1:0] per_irq_en,
   input  logic             cpu_mask,
   output logic             cpu_clk_en,
   output logic [N_PER-1:0] per_clk_en,
   output logic [N_WDT-1:0] wdt_clk_en,
   output logic             exc_start,
   output logic [2:0]       mode
);
   localparam logic [N_PER-1:0] PER_OFF = '0;
   localparam logic [N_WDT-1:0] WDT_ALL = '1;

   if (N_EXT < 1 || N_EXT > 32) begin : g_bad_ext
      $fatal(1, "N_EXT out of range");
   end
   if (N_PER < 1 || N_PER > 64) begin : g_bad_per
      $fatal(1, "N_PER out of range");
   end
   if (N_WDT < 1 || N_WDT > 4) begin : g_bad_wdt
      $fatal(1, "N_WDT out of range");
   end

   logic     wake;
   pm_mode_e st;

   pwr_wake_qual #(.N_EXT(N_EXT), .N_PER(N_PER)) u_wake (
      .nmi(nmi), .ext_irq(ext_irq), .ext_irq_en(ext_irq_en),
      .per_irq(per_irq), .per_irq_en(per_irq_en), .cpu_mask(cpu_mask),
      .wake(wake)
   );

   pwr_mode_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .stby_n(stby_n), .sleep_req(sleep_req),
      .ctl_ssel(ctl_ssel), .ctl_lspd(ctl_lspd), .ctl_wdps(ctl_wdps),
      .wake(wake), .st(st), .exc_start(exc_start)
   );

   pwr_clk_gate_dec #(.N_PER(N_PER), .N_WDT(N_WDT)) u_gate (
      .st(st), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
      .wdt_clk_en(wdt_clk_en)
   );

   assign mode = st;

   // R4
   subslp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 3'd2) |-> (!cpu_clk_en && per_clk_en == PER_OFF && wdt_clk_en == WDT_ALL));

   // R8
   exc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_start |=> !exc_start);

   // R8
   exc_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      exc_start |-> (cpu_clk_en && $past(cpu_clk_en)));

   // R9
   hwstby_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !stby_n |=> (mode == 3'd4 && !exc_start));
endmodule

// File: tb/pwr_mode_seq_test.sv
module pwr_mode_seq_test;
   localparam int NE = 6;
   localparam int NP = 4;
   localparam int NW = 2;

   logic          clk = 1'b0;
   logic          rst_n, stby_n, sleep_req, ctl_ssel, ctl_lspd, ctl_wdps, nmi, cpu_mask;
   logic [NE-1:0] ext_irq, ext_irq_en;
   logic [NP-1:0] per_irq, per_irq_en;
   logic          cpu_clk_en, exc_start;
   logic [NP-1:0] per_clk_en;
   logic [NW-1:0] wdt_clk_en;
   logic [2:0]    mode;

   int    total = 0;
   int    bad = 0;
   bit    done = 0;
   string cur = "R1";

   int m_mode = 0;
   bit m_pend = 0;
   bit m_exc = 0;

   always #4 clk = ~clk;

   pwr_mode_seq #(.N_EXT(NE), .N_PER(NP), .N_WDT(NW)) uut (
      .clk(clk), .rst_n(rst_n), .stby_n(stby_n), .sleep_req(sleep_req),
      .ctl_ssel(ctl_ssel), .ctl_lspd(ctl_lspd), .ctl_wdps(ctl_wdps), .nmi(nmi),
      .ext_irq(ext_irq), .ext_irq_en(ext_irq_en), .per_irq(per_irq),
      .per_irq_en(per_irq_en), .cpu_mask(cpu_mask), .cpu_clk_en(cpu_clk_en),
      .per_clk_en(per_clk_en), .wdt_clk_en(wdt_clk_en), .exc_start(exc_start),
      .mode(mode)
   );

   task automatic model_step();
      bit w;
      bit tk;
      int nm;
      w  = nmi || ((ext_irq & ext_irq_en) != 0) || (!cpu_mask && ((per_irq & per_irq_en) != 0));
      tk = 0;
      nm = m_mode;
      if (!stby_n) nm = 4;
      else if (!rst_n) nm = 0;
      else if (m_mode == 0) begin
         if (sleep_req) begin
            if (ctl_ssel) nm = 3;
            else if (ctl_lspd && ctl_wdps) nm = 2;
            else nm = 1;
         end
      end else if (m_mode >= 1 && m_mode <= 3 && w) begin
         nm = 0;
         tk = 1;
      end
      m_exc  = (stby_n && rst_n) ? m_pend : 1'b0;
      m_pend = (stby_n && rst_n) ? tk : 1'b0;
      m_mode = nm;
   endtask

   task automatic compare();
      bit [NP-1:0] e_per;
      bit [NW-1:0] e_wdt;
      bit          e_cpu;
      e_cpu = (m_mode == 0);
      e_per = (m_mode <= 1) ? '1 : '0;
      e_wdt = (m_mode <= 2) ? '1 : '0;
      total++;
      if (mode !== 3'(m_mode) || cpu_clk_en !== e_cpu || per_clk_en !== e_per ||
          wdt_clk_en !== e_wdt || exc_start !== m_exc) begin
         bad++;
         $display("FAIL %s model: mode=%0d cpu=%b per=%b wdt=%b exc=%b exp mode=%0d cpu=%b per=%b wdt=%b exc=%b",
                  cur, mode, cpu_clk_en, per_clk_en, wdt_clk_en, exc_start,
                  m_mode, e_cpu, e_per, e_wdt, m_exc);
      end
   endtask

   task automatic tick(int n = 1);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         model_step();
         @(negedge clk);
         compare();
      end
   endtask

   task automatic expect_mode(int m, string tag);
      total++;
      if (mode !== 3'(m)) begin
         bad++;
         $display("FAIL %s mode act=%0d exp=%0d", tag, mode, m);
      end
   endtask

   task automatic expect_exc(bit v, string tag);
      total++;
      if (exc_start !== v) begin
         bad++;
         $display("FAIL %s exc_start act=%b exp=%b", tag, exc_start, v);
      end
   endtask

   task automatic go_sleep(bit s, bit l, bit w);
      ctl_ssel = s; ctl_lspd = l; ctl_wdps = w;
      sleep_req = 1;
      tick();
      sleep_req = 0;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired act=hung exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      rst_n = 0; stby_n = 1; sleep_req = 0; ctl_ssel = 0; ctl_lspd = 0; ctl_wdps = 0;
      nmi = 0; cpu_mask = 0; ext_irq = '0; ext_irq_en = '0; per_irq = '0; per_irq_en = '0;
      tick(3);
      cur = "R1"; expect_mode(0, "R1"); expect_exc(0, "R1");
      rst_n = 1; tick(2);

      // R3 / R4: plain sleep, then enabled external line wakes (R5), pulse (R8)
      cur = "R3"; go_sleep(0, 0, 0); expect_mode(1, "R3");
      cur = "R4"; tick(2);
      cur = "R5"; ext_irq_en = 6'b000100; ext_irq = 6'b000100; tick();
      expect_mode(0, "R5"); expect_exc(0, "R8");
      ext_irq = '0; tick(); expect_exc(1, "R8");
      tick(); expect_exc(0, "R8");

      // R2: sub-clock sleep
      cur = "R2"; go_sleep(0, 1, 1); expect_mode(2, "R2");
      cur = "R4"; tick();
      // R6: filtered sources
      cur = "R6"; ext_irq = 6'b111011; tick(); expect_mode(2, "R6");
      ext_irq = '0; per_irq = 4'b0010; per_irq_en = 4'b0001; tick(); expect_mode(2, "R6");
      per_irq_en = 4'b0010; cpu_mask = 1; tick(); expect_mode(2, "R6");
      per_irq = '0;
      // R11
      cur = "R11"; ctl_ssel = 1; sleep_req = 1; tick(); sleep_req = 0; ctl_ssel = 0;
      expect_mode(2, "R11");
      // R7
      cur = "R7"; nmi = 1; tick(); expect_mode(0, "R7"); nmi = 0; tick(); expect_exc(1, "R7");
      cpu_mask = 0; tick();

      // R5 peripheral wake
      cur = "R5"; go_sleep(0, 1, 1); per_irq = 4'b0010; tick(); expect_mode(0, "R5");
      per_irq = '0; tick(2);

      // R3 second qualifier, R3 software standby
      cur = "R3"; go_sleep(0, 1, 0); expect_mode(1, "R3");
      nmi = 1; tick(); nmi = 0; tick(2);
      go_sleep(1, 0, 1); expect_mode(3, "R3");
      cur = "R4"; tick();
      cur = "R5"; ext_irq_en = 6'b000101; ext_irq = 6'b000001; tick(); expect_mode(0, "R5");
      ext_irq = '0; tick(2);

      // R5 each external line in turn
      ext_irq_en = '1;
      for (int i = 0; i < NE; i++) begin
         cur = "R5"; go_sleep(0, 1, 1); expect_mode(2, "R5");
         ext_irq = NE'(1) << i; tick(); expect_mode(0, "R5");
         ext_irq = '0; tick(2);
      end
      ext_irq_en = '0;

      // R1 / R8: reset exit from sub-clock sleep, no pulse
      cur = "R1"; go_sleep(0, 1, 1); rst_n = 0; tick(); expect_mode(0, "R1");
      rst_n = 1; tick(); expect_exc(0, "R8"); tick(); expect_exc(0, "R8");

      // R9 / R10
      cur = "R9"; go_sleep(0, 0, 0); stby_n = 0; tick(); expect_mode(4, "R9");
      cur = "R10"; rst_n = 0; tick(); expect_mode(4, "R10");
      rst_n = 1; nmi = 1; tick(); expect_mode(4, "R10"); nmi = 0;
      stby_n = 1; tick(); expect_mode(4, "R10");
      ext_irq_en = '1; ext_irq = '1; tick(); expect_mode(4, "R10"); ext_irq = '0; ext_irq_en = '0;
      sleep_req = 1; tick(); sleep_req = 0; expect_mode(4, "R10");
      rst_n = 0; tick(); expect_mode(0, "R10"); rst_n = 1; tick();
      cur = "R9"; stby_n = 0; tick(); expect_mode(4, "R9");
      rst_n = 0; tick(); expect_mode(4, "R9");
      stby_n = 1; tick(); expect_mode(0, "R9"); rst_n = 1; tick(2);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule